// File: doc/BRIEF.md
# Programmable Interlaced Video Timing Generator

This block produces the horizontal and vertical timing for a digital video output whose raster is chosen at run time, for example a nonstandard 1316x480 interlaced frame. A horizontal counter walks each line and a field state machine counts lines within each field. From the counter position the block derives active-low horizontal and vertical sync, an active-video flag, a field flag and an 8-bit multiplexed YCbCr byte stream. That stream can carry an eight-bar colour test pattern, and its component order is selectable.

All raster values are inputs and must be held steady while `enable` is high. The intended use is to drop `enable`, load a new raster, then raise it again. When `enable` is low the counters, the field state machine and the sync delay lines are held cleared.

The field state machine has three states. `ST_OFF` is the disabled state. `ST_FIELD1` is the first field, and the only field in progressive mode. `ST_FIELD2` is the second interlaced field. The transitions are:
- OFF to FIELD1 when enable is high.
- FIELD1 to FIELD2 at the end of the last line of field one, in interlaced mode.
- FIELD1 to FIELD1 at that same point, in progressive mode.
- FIELD2 to FIELD1 at the end of the last line of field two.
- Any state to OFF when enable falls.

Top module: `vid_timing_gen`

## Requirements
- R1: While `enable` is low, the counters and delay lines are held cleared. One clock after a cycle with `enable` low, the outputs are `hsync_n`=1, `vsync_n`=1, `active`=0, `field`=0 and `data`=0x10. When `enable` rises, the raster starts at line 0, column 0 of field one.
- R2: A line lasts `h_total`+1 clocks. The raw horizontal sync is asserted on columns 0 to `h_sync_w`-1. Every output appears one clock after the counter position that produced it.
- R3: In progressive mode (`interlace`=0), a frame is `v_total`+1 lines long, and `field` stays 0.
- R4: In field one, the raw vertical sync is asserted on lines 0 to `v_sync_w`-1 of the field, for whole lines.
- R5: In interlaced mode, let N = `v_total`+1. Field one (`field`=0) has ceil(N/2) lines and field two (`field`=1) has floor(N/2) lines, and the two fields alternate.
- R6: In field two, the vertical sync starts and ends half a line late. The half point is column floor((`h_total`+1)/2). Sync is asserted from that column of line 0 up to just before that column of line `v_sync_w`.
- R7: When `v_sync_w` is greater than `v_total`, vertical sync is asserted continuously while enabled.
- R8: `active` is high when both conditions hold. The column must lie in [`h_act_start`, `h_act_start`+`h_act_len`). The line within the field must lie in [S, S+`v_act_len`), where S is `v_act_start` in field one and `v_act_start_f2` in field two.
- R9: With `bar_en`=1, active bytes take the colour of bar min(7, p / max(1, floor(`h_act_len`/8))), where p is the column minus `h_act_start`. The bars in order are given as Y/Cb/Cr:
  - 180/128/128
  - 162/44/142
  - 131/156/44
  - 112/72/58
  - 84/184/198
  - 65/100/212
  - 35/212/114
  - 16/128/128
- R10: The byte phase is (column − `h_act_start`) mod 4. `order` picks the component for phases 0 to 3 as follows:
  - 0 gives Cb,Y,Cr,Y
  - 1 gives Y,Cr,Y,Cb
  - 2 gives Cr,Y,Cb,Y
  - 3 gives Y,Cb,Y,Cr
- R11: Outside the active window, or with `bar_en`=0, the bytes carry black in the same order: Y=0x10, Cb=Cr=0x80.
- R12: With `csync_en`=1, the raw horizontal sync is replaced by the exclusive-OR of the raw horizontal and vertical syncs. This inverts the line pulses during the vertical interval.
- R13: `hsync_n` and `vsync_n` are the inverted raw syncs delayed by a further `hs_dly` and `vs_dly` clocks respectively. A value of 0 adds no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master run enable |
| interlace | input | 1 | 1 = two fields per frame |
| h_total | input | 12 | Clocks per line minus one |
| h_sync_w | input | 12 | Horizontal sync width in clocks |
| h_act_start | input | 12 | First active column |
| h_act_len | input | 12 | Active columns per line |
| v_total | input | 11 | Lines per frame minus one |
| v_sync_w | input | 11 | Vertical sync width in lines |
| v_act_start | input | 11 | First active line, field one |
| v_act_start_f2 | input | 11 | First active line, field two |
| v_act_len | input | 11 | Active lines per field |
| hs_dly | input | 4 | Extra horizontal sync delay in clocks |
| vs_dly | input | 4 | Extra vertical sync delay in clocks |
| bar_en | input | 1 | Colour-bar pattern enable |
| order | input | 2 | Byte order select |
| csync_en | input | 1 | Composite sync on hsync_n |
| hsync_n | output | 1 | Horizontal or composite sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Active-video flag |
| field | output | 1 | 1 during field two |
| data | output | 8 | Multiplexed YCbCr byte |

## Verification
The bench targets each of the following corner cases:
- **Odd line count in interlaced mode.** A design that splits the two fields equally, or sizes field two from field one, drifts the field flag and the second field's active start by one line.
- **Half-line offset of vertical sync in field two.** Getting it wrong moves the sync edge by half a line, which shows up only on the field-two `vsync_n` transitions.
- **Vertical sync width above the frame length.** A design that wraps the comparison emits periodic pulses instead of holding sync low.
- **Sync delays and composite mode.** Wrong delays shift edges by a few clocks, and an incorrect composite XOR leaves the line pulses uninverted during vertical sync.
- **Bar boundaries, byte orders and the short-line case.** The bench runs a 1316-clock active line, all four byte orders, and an active line shorter than eight clocks. A wrong bar width or component lane corrupts individual bytes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FIELD1 = 2'd1,
        ST_FIELD2 = 2'd2
    } vtg_state_e;

    localparam logic [7:0] Y_BLACK   = 8'h10;
    localparam logic [7:0] C_NEUTRAL = 8'h80;

    // Eight test bars with luma stepping down from white to black.
    function automatic logic [7:0] bar_luma(input logic [2:0] idx);
        unique case (idx)
            3'd0: bar_luma = 8'd180;
            3'd1: bar_luma = 8'd162;
            3'd2: bar_luma = 8'd131;
            3'd3: bar_luma = 8'd112;
            3'd4: bar_luma = 8'd84;
            3'd5: bar_luma = 8'd65;
            3'd6: bar_luma = 8'd35;
            default: bar_luma = 8'd16;
        endcase
    endfunction

    function automatic logic [7:0] bar_cb(input logic [2:0] idx);
        unique case (idx)
            3'd0: bar_cb = 8'd128;
            3'd1: bar_cb = 8'd44;
            3'd2: bar_cb = 8'd156;
            3'd3: bar_cb = 8'd72;
            3'd4: bar_cb = 8'd184;
            3'd5: bar_cb = 8'd100;
            3'd6: bar_cb = 8'd212;
            default: bar_cb = 8'd128;
        endcase
    endfunction

    function automatic logic [7:0] bar_cr(input logic [2:0] idx);
        unique case (idx)
            3'd0: bar_cr = 8'd128;
            3'd1: bar_cr = 8'd142;
            3'd2: bar_cr = 8'd44;
            3'd3: bar_cr = 8'd58;
            3'd4: bar_cr = 8'd198;
            3'd5: bar_cr = 8'd212;
            3'd6: bar_cr = 8'd114;
            default: bar_cr = 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] h_total,
    output logic [HW-1:0] hcnt,
    output logic          line_end
);

    assign line_end = run && (hcnt == h_total);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!run || line_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R2
    hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= h_total);

endmodule

// File: rtl/vtg_field_fsm.sv
module vtg_field_fsm
    import vtg_pkg::*;
#(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          interlace,
    input  logic          line_end,
    input  logic [VW-1:0] v_total,
    output logic [VW-1:0] lcnt,
    output logic          field
);

    vtg_state_e state_q, state_d;

    logic [VW:0] n_lines;
    logic [VW:0] f1_len;
    logic [VW:0] f2_len;
    logic [VW:0] last_line;
    logic        field_end;

    assign n_lines   = {1'b0, v_total} + (VW+1)'(1);
    assign f1_len    = interlace ? ((n_lines + (VW+1)'(1)) >> 1) : n_lines;
    assign f2_len    = n_lines >> 1;
    assign last_line = ((state_q == ST_FIELD2) ? f2_len : f1_len) - (VW+1)'(1);
    assign field_end = line_end && ({1'b0, lcnt} == last_line);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable) begin
                    state_d = (field_end && interlace) ? ST_FIELD2 : ST_FIELD1;
                end
            end
            ST_FIELD1: begin
                if (!enable) begin
                    state_d = ST_OFF;
                end else if (field_end && interlace) begin
                    state_d = ST_FIELD2;
                end
            end
            ST_FIELD2: begin
                if (!enable) begin
                    state_d = ST_OFF;
                end else if (field_end) begin
                    state_d = ST_FIELD1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs: line counter within the field, field flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt <= '0;
        end else if (!enable || field_end) begin
            lcnt <= '0;
        end else if (line_end) begin
            lcnt <= lcnt + 1'b1;
        end
    end

    assign field = (state_q == ST_FIELD2);

    // R3
    lcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcnt <= v_total);

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && enable && !field_end) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/vtg_sync_gen.sv
module vtg_sync_gen #(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] lcnt,
    input  logic          field,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_sync_w,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_sync_w,
    input  logic          csync_en,
    input  logic [DW-1:0] hs_dly,
    input  logic [DW-1:0] vs_dly,
    output logic          hsync_n,
    output logic          vsync_n
);

    localparam int DEPTH = 2 ** DW;

    logic [HW:0]      half;
    logic             hs_raw;
    logic             vs_cont;
    logic             vs_f1;
    logic             vs_f2;
    logic             f2_started;
    logic             f2_before_end;
    logic             vs_raw;
    logic             h_comb;
    logic [DEPTH-1:0] hs_line;
    logic [DEPTH-1:0] vs_line;

    assign half          = ({1'b0, h_total} + (HW+1)'(1)) >> 1;
    assign hs_raw        = hcnt < h_sync_w;
    assign vs_cont       = v_sync_w > v_total;
    assign vs_f1         = lcnt < v_sync_w;
    assign f2_started    = (lcnt != '0) || ({1'b0, hcnt} >= half);
    assign f2_before_end = (lcnt < v_sync_w) || ((lcnt == v_sync_w) && ({1'b0, hcnt} < half));
    assign vs_f2         = (v_sync_w != '0) && f2_started && f2_before_end;
    assign vs_raw        = vs_cont || (field ? vs_f2 : vs_f1);
    assign h_comb        = csync_en ? (hs_raw ^ vs_raw) : hs_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_line <= '0;
            vs_line <= '0;
        end else if (!enable) begin
            hs_line <= '0;
            vs_line <= '0;
        end else begin
            hs_line <= {hs_line[DEPTH-2:0], h_comb};
            vs_line <= {vs_line[DEPTH-2:0], vs_raw};
        end
    end

    assign hsync_n = ~hs_line[hs_dly];
    assign vsync_n = ~vs_line[vs_dly];

    // R7
    vs_continuous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (v_sync_w > v_total)) |=> vs_line[0]);

endmodule

// File: rtl/vtg_pixfmt.sv
module vtg_pixfmt
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] lcnt,
    input  logic          field,
    input  logic [HW-1:0] h_act_start,
    input  logic [HW-1:0] h_act_len,
    input  logic [VW-1:0] v_act_start,
    input  logic [VW-1:0] v_act_start_f2,
    input  logic [VW-1:0] v_act_len,
    input  logic          bar_en,
    input  logic [1:0]    order,
    output logic          active_o,
    output logic [7:0]    data_o
);

    localparam int NBARS = 8;
    localparam int TW    = HW + 3;

    logic [HW:0]      h_end;
    logic [VW-1:0]    v_first;
    logic [VW:0]      v_end;
    logic             h_in;
    logic             v_in;
    logic             in_win;
    logic [HW-1:0]    pidx;
    logic [1:0]       phase;
    logic [HW-1:0]    bar_w;
    logic [NBARS-2:0] past_thr;
    logic [2:0]       bar;
    logic [7:0]       y_v, cb_v, cr_v;
    logic             is_luma;
    logic             is_cb;
    logic [7:0]       byte_d;

    assign h_end   = {1'b0, h_act_start} + {1'b0, h_act_len};
    assign v_first = field ? v_act_start_f2 : v_act_start;
    assign v_end   = {1'b0, v_first} + {1'b0, v_act_len};
    assign h_in    = (hcnt >= h_act_start) && ({1'b0, hcnt} < h_end);
    assign v_in    = (lcnt >= v_first) && ({1'b0, lcnt} < v_end);
    assign in_win  = h_in && v_in;

    assign pidx    = hcnt - h_act_start;
    assign phase   = pidx[1:0];
    assign bar_w   = ((h_act_len >> 3) == '0) ? HW'(1) : (h_act_len >> 3);

    // One comparator per bar boundary; the count of passed boundaries is the bar.
    for (genvar k = 1; k < NBARS; k++) begin : g_thr
        logic [TW-1:0] thr;
        assign thr           = {3'b000, bar_w} * TW'(k);
        assign past_thr[k-1] = {3'b000, pidx} >= thr;
    end

    always_comb begin
        bar = '0;
        for (int i = 0; i < NBARS - 1; i++) begin
            bar = bar + {2'b00, past_thr[i]};
        end
    end

    always_comb begin
        if (in_win && bar_en) begin
            y_v  = bar_luma(bar);
            cb_v = bar_cb(bar);
            cr_v = bar_cr(bar);
        end else begin
            y_v  = Y_BLACK;
            cb_v = C_NEUTRAL;
            cr_v = C_NEUTRAL;
        end
    end

    assign is_luma = order[0] ? ~phase[0] : phase[0];
    assign is_cb   = ~(phase[1] ^ order[1] ^ order[0]);
    assign byte_d  = is_luma ? y_v : (is_cb ? cb_v : cr_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            data_o   <= Y_BLACK;
        end else if (!enable) begin
            active_o <= 1'b0;
            data_o   <= Y_BLACK;
        end else begin
            active_o <= in_win;
            data_o   <= byte_d;
        end
    end

    // R11
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (data_o == Y_BLACK || data_o == C_NEUTRAL));

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          interlace,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_sync_w,
    input  logic [HW-1:0] h_act_start,
    input  logic [HW-1:0] h_act_len,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_sync_w,
    input  logic [VW-1:0] v_act_start,
    input  logic [VW-1:0] v_act_start_f2,
    input  logic [VW-1:0] v_act_len,
    input  logic [DW-1:0] hs_dly,
    input  logic [DW-1:0] vs_dly,
    input  logic          bar_en,
    input  logic [1:0]    order,
    input  logic          csync_en,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          active,
    output logic          field,
    output logic [7:0]    data
);

    logic [HW-1:0] hcnt;
    logic          line_end;
    logic [VW-1:0] lcnt;
    logic          fld;
    logic          field_q;

    vtg_hcount #(.HW(HW)) u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .h_total  (h_total),
        .hcnt     (hcnt),
        .line_end (line_end)
    );

    vtg_field_fsm #(.VW(VW)) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .interlace (interlace),
        .line_end  (line_end),
        .v_total   (v_total),
        .lcnt      (lcnt),
        .field     (fld)
    );

    vtg_sync_gen #(.HW(HW), .VW(VW), .DW(DW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .hcnt     (hcnt),
        .lcnt     (lcnt),
        .field    (fld),
        .h_total  (h_total),
        .h_sync_w (h_sync_w),
        .v_total  (v_total),
        .v_sync_w (v_sync_w),
        .csync_en (csync_en),
        .hs_dly   (hs_dly),
        .vs_dly   (vs_dly),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n)
    );

    vtg_pixfmt #(.HW(HW), .VW(VW)) u_pix (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .hcnt           (hcnt),
        .lcnt           (lcnt),
        .field          (fld),
        .h_act_start    (h_act_start),
        .h_act_len      (h_act_len),
        .v_act_start    (v_act_start),
        .v_act_start_f2 (v_act_start_f2),
        .v_act_len      (v_act_len),
        .bar_en         (bar_en),
        .order          (order),
        .active_o       (active),
        .data_o         (data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= 1'b0;
        end else if (!enable) begin
            field_q <= 1'b0;
        end else begin
            field_q <= fld;
        end
    end

    assign field = field_q;

    // R1
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hsync_n && vsync_n && !active && !field && data == 8'h10));

endmodule

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;

    localparam int HW = 12;
    localparam int VW = 11;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          interlace = 1'b0;
    logic [HW-1:0] h_total = '0, h_sync_w = '0, h_act_start = '0, h_act_len = '0;
    logic [VW-1:0] v_total = '0, v_sync_w = '0, v_act_start = '0, v_act_start_f2 = '0, v_act_len = '0;
    logic [DW-1:0] hs_dly = '0, vs_dly = '0;
    logic          bar_en = 1'b0;
    logic [1:0]    order = 2'd0;
    logic          csync_en = 1'b0;
    logic          hsync_n, vsync_n, active, field;
    logic [7:0]    data;

    always #2 clk = ~clk;

    vid_timing_gen #(.HW(HW), .VW(VW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .interlace(interlace),
        .h_total(h_total), .h_sync_w(h_sync_w), .h_act_start(h_act_start), .h_act_len(h_act_len),
        .v_total(v_total), .v_sync_w(v_sync_w), .v_act_start(v_act_start),
        .v_act_start_f2(v_act_start_f2), .v_act_len(v_act_len),
        .hs_dly(hs_dly), .vs_dly(vs_dly), .bar_en(bar_en), .order(order), .csync_en(csync_en),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active), .field(field), .data(data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase_tag = "R1";
    bit cmp_on = 1'b0;

    // Reference model state
    int mh = 0, ml = 0, mf = 0;
    logic [15:0] hh = '0, vh = '0;
    bit   e_act = 0, e_field = 0;
    int   e_data = 16;

    int ty [8] = '{180, 162, 131, 112, 84, 65, 35, 16};
    int tcb[8] = '{128, 44, 156, 72, 184, 100, 212, 128};
    int tcr[8] = '{128, 142, 44, 58, 198, 212, 114, 128};

    function automatic int pick(int ord, int ph, int y, int cb, int cr);
        int r;
        case (ord)
            0: r = (ph == 0) ? cb : (ph == 2) ? cr : y;
            1: r = (ph == 1) ? cr : (ph == 3) ? cb : y;
            2: r = (ph == 0) ? cr : (ph == 2) ? cb : y;
            default: r = (ph == 1) ? cb : (ph == 3) ? cr : y;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            mh = 0; ml = 0; mf = 0;
            hh = '0; vh = '0;
            e_act = 0; e_data = 16; e_field = 0;
        end else begin
            int ht, hsw, hst, hln, vt, vsw, vst, vln, half, p, bw, bi, y, cb, cr, flen;
            bit hs, vs;
            ht = int'(h_total); hsw = int'(h_sync_w); hst = int'(h_act_start); hln = int'(h_act_len);
            vt = int'(v_total); vsw = int'(v_sync_w); vln = int'(v_act_len);
            vst = (mf == 1) ? int'(v_act_start_f2) : int'(v_act_start);
            half = (ht + 1) / 2;
            hs = (mh < hsw);
            if (vsw > vt) vs = 1;
            else if (mf == 0) vs = (ml < vsw);
            else vs = (vsw != 0) && (ml > 0 || mh >= half) && (ml < vsw || (ml == vsw && mh < half));
            if (csync_en) hs = hs ^ vs;
            hh = {hh[14:0], hs};
            vh = {vh[14:0], vs};
            e_field = (mf == 1);
            e_act = (mh >= hst) && (mh < hst + hln) && (ml >= vst) && (ml < vst + vln);
            p = mh - hst;
            y = 16; cb = 128; cr = 128;
            if (e_act && bar_en) begin
                bw = hln / 8;
                if (bw == 0) bw = 1;
                bi = p / bw;
                if (bi > 7) bi = 7;
                y = ty[bi]; cb = tcb[bi]; cr = tcr[bi];
            end
            e_data = pick(int'(order), p & 3, y, cb, cr);
            mh++;
            if (mh > ht) begin
                mh = 0;
                ml++;
                if (!interlace) flen = vt + 1;
                else flen = (mf == 0) ? (vt + 2) / 2 : (vt + 1) / 2;
                if (ml >= flen) begin
                    ml = 0;
                    mf = interlace ? 1 - mf : 0;
                end
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(phase_tag, "hsync_n", int'(hsync_n), int'(!hh[hs_dly]));
            check(phase_tag, "vsync_n", int'(vsync_n), int'(!vh[vs_dly]));
            check(phase_tag, "active", int'(active), int'(e_act));
            check(phase_tag, "field", int'(field), int'(e_field));
            check(phase_tag, "data", int'(data), e_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg(int ht, int hsw, int hst, int hln, int vt, int vsw, int vst, int vst2, int vln);
        h_total = HW'(ht); h_sync_w = HW'(hsw); h_act_start = HW'(hst); h_act_len = HW'(hln);
        v_total = VW'(vt); v_sync_w = VW'(vsw); v_act_start = VW'(vst);
        v_act_start_f2 = VW'(vst2); v_act_len = VW'(vln);
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_run(int cycles);
        @(negedge clk);
        enable = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1", "reset hsync_n", int'(hsync_n), 1);
        check("R1", "reset vsync_n", int'(vsync_n), 1);
        check("R1", "reset active", int'(active), 0);
        check("R1", "reset data", int'(data), 16);
        cmp_on = 1'b1;

        // Progressive raster, line length, frame length, whole-line vsync
        phase_tag = "R2 R3 R4 R8";
        cfg(39, 5, 8, 24, 19, 3, 4, 4, 10);
        bar_en = 1'b1; order = 2'd0;
        start_run(40 * 20 * 2 + 7);

        // R1: disable mid-frame, outputs go idle one clock later
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R1", "disabled hsync_n", int'(hsync_n), 1);
        check("R1", "disabled vsync_n", int'(vsync_n), 1);
        check("R1", "disabled active", int'(active), 0);
        check("R1", "disabled data", int'(data), 16);
        repeat (2) @(negedge clk);

        // Interlaced, odd line count, separate field-two start
        phase_tag = "R5 R6 R8";
        interlace = 1'b1;
        cfg(39, 5, 8, 24, 20, 3, 4, 6, 4);
        start_run(40 * 21 * 3);

        // Byte orders
        for (int o = 1; o < 4; o++) begin
            stop_run();
            phase_tag = "R10";
            order = 2'(o);
            start_run(40 * 21);
        end

        // Continuous vsync
        stop_run();
        phase_tag = "R7";
        cfg(39, 5, 8, 24, 20, 25, 4, 6, 4);
        start_run(40 * 21);

        // Composite sync
        stop_run();
        phase_tag = "R12";
        csync_en = 1'b1;
        cfg(39, 5, 8, 24, 20, 3, 4, 6, 4);
        start_run(40 * 21 * 2);

        // Sync delays
        stop_run();
        phase_tag = "R13";
        csync_en = 1'b0;
        hs_dly = 4'd3; vs_dly = 4'd7;
        start_run(40 * 21 * 2);
        stop_run();
        hs_dly = 4'd15; vs_dly = 4'd0;
        start_run(40 * 21);

        // Wide active line with bars, progressive
        stop_run();
        phase_tag = "R9";
        hs_dly = 4'd0;
        interlace = 1'b0; order = 2'd3;
        cfg(1399, 60, 40, 1316, 9, 2, 2, 2, 5);
        start_run(1400 * 10);

        // Very short active line: bar width floors to one clock
        stop_run();
        cfg(39, 5, 10, 5, 9, 2, 1, 1, 6);
        start_run(40 * 10);

        // Bars disabled: active area carries black
        stop_run();
        phase_tag = "R11";
        bar_en = 1'b0; order = 2'd1;
        cfg(39, 5, 8, 24, 9, 2, 1, 1, 6);
        start_run(40 * 10);

        stop_run();
        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule